// File: doc/BRIEF.md
# Way-Masked Random Victim Selector

This block picks which way of a four-way set-associative cache is evicted on a miss. The choice is pseudo-random, but a per-way enable mask restricts it: a way whose enable bit is clear is never offered as a victim. The cache controller can then leave that way's contents alone and use it as directly addressed on-chip RAM. The tag and data arrays, error correction, line fill and the bus fabric sit outside this block.

The mask is loaded in an unusual way. Any bus write that lands in a dedicated address window copies four address bits into the mask, and the write data is discarded. This means software selects the new mask by choosing which address to store to. A second window returns the mask on a read. A replacement request is answered one clock later with a victim way, a valid pulse and an error flag. The error flag is raised when the mask is all zero, which is not a supported configuration.

Top module: `way_victim_sel`

## Requirements
- R1: After reset the enable mask is 4'b1111 (every way enabled) and `victim_valid` is low.
- R2: A write (`bus_wr` high) whose address bits [39:12] equal the write-window base loads address bits [11:8] into the mask, with bit n enabling way n. The values on `bus_wdata` and on address bits [7:0] have no effect on the result.
- R3: A write whose address bits [39:12] differ from the write-window base leaves the mask unchanged.
- R4: A write to address 40'h00_1004_1B00 (bit 10 clear; bits 11, 9 and 8 set) with the default base disables way 2 only, so the mask becomes 4'b1011.
- R5: While `bus_rd` is high and address bits [39:12] equal the status-window base, `rd_data` shows the current mask. At all other times `rd_data` is zero. The read is combinational.
- R6: A 16-bit LFSR is seeded with 16'hACE1 by reset. On every clock after reset it shifts toward its MSB, and the new bit 0 is the XOR of the old bits 15, 13, 12 and 10. The LFSR's bits [1:0] give the start way for a request.
- R7: When `victim_req` is high in a cycle, `victim_valid` is high for exactly the following cycle. `victim_valid` is never high without a request in the cycle before it.
- R8: When the mask is non-zero, `victim_way` is the first enabled way found by scanning upward from the start way, wrapping from 3 to 0, and `victim_err` is low. This way is therefore always an enabled way.
- R9: When the mask is all zero, `victim_way` equals the start way and `victim_err` is high.
- R10: A request uses the mask as it stood before any mask write made in the same cycle. The new mask applies only to requests in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 40 | Byte address of the bus access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data; has no effect on this block |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 4 | Mask readback; zero when the status window is not being read |
| victim_req | input | 1 | Replacement request |
| victim_valid | output | 1 | One-cycle pulse marking a victim answer |
| victim_way | output | 2 | Chosen victim way |
| victim_err | output | 1 | High when the answer was produced with an all-zero mask |

## Verification
A corrupted mask shows up at the `rd_data` port as soon as the status window is read. It also shows up at `victim_way` on the next request whose start way meets the corrupted bit, which is at most a few requests away. A generator state that is off by even one step changes the start way within a cycle or two, so the per-clock reference comparison catches it as a wrong victim almost immediately. A misplaced output register shows up as a valid pulse that is one cycle early or late. A mask that updates too early shows up on the one cycle where a write and a request coincide.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
    localparam int NUM_WAYS  = 4;
    localparam int WAY_W     = $clog2(NUM_WAYS);
    localparam int FIELD_LSB = 8;
    localparam int HI_LSB    = FIELD_LSB + NUM_WAYS;
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef struct packed {
        logic             valid;
        logic [WAY_W-1:0] way;
        logic             err;
    } victim_resp_t;
endpackage

// File: rtl/wvs_lfsr.sv
module wvs_lfsr
    import wvs_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);
    typedef struct packed {
        logic [LFSR_W-1:0] bits;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = {st_q.bits[LFSR_W-2:0], ^(st_q.bits & LFSR_TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: SEED};
        else        st_q <= st_d;
    end

    assign state = st_q.bits;
endmodule

// File: rtl/wvs_way_mask.sv
module wvs_way_mask
    import wvs_pkg::*;
#(
    parameter int HI_W = 28,
    parameter logic [HI_W-1:0] WIN_BASE  = '0,
    parameter logic [HI_W-1:0] STAT_BASE = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HI_W-1:0]     addr_hi,
    input  logic [NUM_WAYS-1:0] addr_field,
    input  logic                wr,
    input  logic                rd,
    output logic [NUM_WAYS-1:0] mask,
    output logic [NUM_WAYS-1:0] rd_data
);
    typedef struct packed {
        logic [NUM_WAYS-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic     win_hit, stat_hit;

    always_comb begin
        win_hit  = (addr_hi == WIN_BASE);
        stat_hit = (addr_hi == STAT_BASE);
        st_d     = st_q;
        if (wr && win_hit) st_d.en = addr_field;
        rd_data  = (rd && stat_hit) ? st_q.en : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: '1};
        else        st_q <= st_d;
    end

    assign mask = st_q.en;
endmodule

// File: rtl/wvs_pick.sv
module wvs_pick
    import wvs_pkg::*;
(
    input  logic [NUM_WAYS-1:0] mask,
    input  logic [WAY_W-1:0]    start,
    output logic [WAY_W-1:0]    way,
    output logic                none
);
    logic [WAY_W-1:0]    cand [NUM_WAYS];
    logic [NUM_WAYS-1:0] hit;

    for (genvar i = 0; i < NUM_WAYS; i++) begin : g_cand
        assign cand[i] = start + WAY_W'(i);
        assign hit[i]  = mask[cand[i]];
    end

    always_comb begin
        way  = start;
        none = (mask == '0);
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            if (hit[k]) way = cand[k];
        end
    end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import wvs_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 64,
    parameter logic [ADDR_W-HI_LSB-1:0] WIN_BASE  = 28'h0010041,
    parameter logic [ADDR_W-HI_LSB-1:0] STAT_BASE = 28'h0010042,
    parameter logic [LFSR_W-1:0]        LFSR_SEED = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [NUM_WAYS-1:0] rd_data,
    input  logic                victim_req,
    output logic                victim_valid,
    output logic [WAY_W-1:0]    victim_way,
    output logic                victim_err
);
    localparam int HI_W = ADDR_W - HI_LSB;

    logic [NUM_WAYS-1:0] mask_q;
    logic [LFSR_W-1:0]   lfsr_q;
    logic [WAY_W-1:0]    pick_way;
    logic                pick_none;
    logic                unused_bits;

    victim_resp_t resp_d, resp_q;

    assign unused_bits = ^{bus_wdata, bus_addr[FIELD_LSB-1:0], lfsr_q[LFSR_W-1:WAY_W]};

    wvs_way_mask #(
        .HI_W      (HI_W),
        .WIN_BASE  (WIN_BASE),
        .STAT_BASE (STAT_BASE)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_hi    (bus_addr[ADDR_W-1:HI_LSB]),
        .addr_field (bus_addr[HI_LSB-1:FIELD_LSB]),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .mask       (mask_q),
        .rd_data    (rd_data)
    );

    wvs_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    wvs_pick u_pick (
        .mask  (mask_q),
        .start (lfsr_q[WAY_W-1:0]),
        .way   (pick_way),
        .none  (pick_none)
    );

    always_comb begin
        resp_d       = resp_q;
        resp_d.valid = victim_req;
        if (victim_req) begin
            resp_d.way = pick_way;
            resp_d.err = pick_none;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign victim_valid = resp_q.valid;
    assign victim_way   = resp_q.way;
    assign victim_err   = resp_q.err;
endmodule

// File: rtl/wvs_chk.sv
module wvs_chk
    import wvs_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                victim_req,
    input logic                victim_valid,
    input logic [WAY_W-1:0]    victim_way,
    input logic                victim_err,
    input logic [NUM_WAYS-1:0] mask_q,
    input logic [LFSR_W-1:0]   lfsr_q
);
    // R1
    reset_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && !victim_valid));

    // R6
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> lfsr_q == {$past(lfsr_q[LFSR_W-2:0]), ^($past(lfsr_q) & LFSR_TAPS)});

    // R7
    req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_req |=> victim_valid);

    // R7
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(victim_req));

    // R8
    enabled_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !victim_err) |-> ((($past(mask_q) >> victim_way) & NUM_WAYS'(1)) != '0));

    // R9
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (victim_err == ($past(mask_q) == '0)));

    // R9
    zero_mask_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && victim_err) |-> victim_way == $past(lfsr_q[WAY_W-1:0]));
endmodule

bind way_victim_sel wvs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .victim_req   (victim_req),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .victim_err   (victim_err),
    .mask_q       (mask_q),
    .lfsr_q       (lfsr_q)
);

// File: tb/way_victim_sel_test.sv
module way_victim_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [27:0] WIN  = 28'h0010041;
    localparam logic [27:0] STAT = 28'h0010042;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [39:0] bus_addr = '0;
    logic        bus_wr = 0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rd = 0;
    logic [3:0]  rd_data;
    logic        victim_req = 0;
    logic        victim_valid;
    logic [1:0]  victim_way;
    logic        victim_err;

    int n_chk = 0, n_err = 0;
    int m_lfsr, m_mask, e_valid, e_way, e_err;
    bit model_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    way_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
        .victim_req(victim_req), .victim_valid(victim_valid),
        .victim_way(victim_way), .victim_err(victim_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, behavioural, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 16'hACE1; m_mask = 15; e_valid = 0; e_way = 0; e_err = 0;
        end else begin
            e_valid = victim_req;
            if (victim_req) begin
                int s;
                s = m_lfsr % 4;
                if (m_mask == 0) begin
                    e_way = s; e_err = 1;
                end else begin
                    e_err = 0;
                    for (int k = 0; k < 4; k++) begin
                        if ((m_mask >> ((s + k) % 4)) % 2 == 1) begin
                            e_way = (s + k) % 4;
                            break;
                        end
                    end
                end
            end
            if (bus_wr && bus_addr[39:12] == WIN) m_mask = int'(bus_addr[11:8]);
            m_lfsr = ((m_lfsr * 2) + (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) % 2)) % 65536;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R7 valid", int'(victim_valid), e_valid);
            if (e_valid != 0) begin
                chk("R6/R8 way", int'(victim_way), e_way);
                chk("R9 err", int'(victim_err), e_err);
            end
            chk("R5 readback", int'(rd_data),
                (bus_rd && bus_addr[39:12] == STAT) ? m_mask : 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic put_mask(input logic [27:0] hi, input logic [3:0] f, input bit req);
        bus_addr = {hi, f, 8'($urandom)};
        bus_wdata = {$urandom, $urandom};
        bus_wr = 1; victim_req = req;
        idle(1);
        bus_wr = 0; victim_req = 0;
    endtask

    task automatic read_mask(input string tag, input int exp);
        bus_addr = {STAT, 12'h5A3};
        bus_rd = 1;
        #1;
        chk(tag, int'(rd_data), exp);
        idle(1);
        bus_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        chk("R1 valid after reset", int'(victim_valid), 0);
        model_on = 1;
        read_mask("R1 reset mask", 15);

        // R6 R8: full mask, back-to-back requests
        victim_req = 1; idle(20); victim_req = 0; idle(1);

        // R4: way 2 removed, data ignored
        put_mask(WIN, 4'hB, 0);
        read_mask("R4 way2 disabled", 4'hB);
        victim_req = 1;
        repeat (30) begin
            idle(1);
            chk("R8 never way2", int'(victim_way == 2'd2), 0);
        end
        victim_req = 0; idle(1);

        // R3: writes just outside the window
        put_mask(WIN + 28'd1, 4'h0, 0);
        put_mask(STAT, 4'h0, 0);
        read_mask("R3 outside window", 4'hB);

        // R2: single way enabled, low address bits and data random
        put_mask(WIN, 4'h1, 0);
        read_mask("R2 mask load", 1);
        victim_req = 1;
        repeat (8) begin idle(1); chk("R8 only way0", int'(victim_way), 0); end
        victim_req = 0; idle(1);

        // R10: write and request in the same cycle
        put_mask(WIN, 4'h8, 1);
        chk("R10 old mask used", int'(victim_way), 0);
        victim_req = 1; idle(1); victim_req = 0;
        chk("R10 new mask later", int'(victim_way), 3);

        // R9: all-zero mask
        put_mask(WIN, 4'h0, 0);
        victim_req = 1;
        repeat (6) begin idle(1); chk("R9 err raised", int'(victim_err), 1); end
        victim_req = 0; idle(1);
        put_mask(WIN, 4'hF, 0);
        read_mask("R2 restore", 15);

        // Mixed traffic, compared by the model every cycle
        for (int i = 0; i < 400; i++) begin
            victim_req = 1'($urandom);
            bus_rd = 1'($urandom);
            bus_wr = ($urandom % 6) == 0;
            bus_addr = {(($urandom % 3) == 0) ? STAT : WIN, 4'($urandom), 8'($urandom)};
            bus_wdata = {$urandom, $urandom};
            idle(1);
        end
        victim_req = 0; bus_wr = 0; bus_rd = 0;
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule